// File: doc/BRIEF.md
# Interrupt Destination Set Resolver

This block turns the addressing fields of an inter-processor or message-signalled interrupt into a bitmask of target processor agents. It has one bit per agent. Each agent supplies three things: its physical ID, its logical-destination byte, and a 4-bit model code. The model code picks how that agent is matched in logical mode. A request is either a direct request or a message-signalled write. A direct request carries a destination, a physical/logical select, a 2-bit shorthand, the sender's index, a delivery mode, a vector and a trigger bit. A message-signalled write carries a raw address word and a raw data word, and the block decodes the same fields from them.

The matching logic is purely combinational. Its result is captured into a single output register that has a valid/ready handshake. A new request is taken whenever that register is empty or is being drained in the same cycle. When the delivery mode is lowest-priority, the resolved set is cut down to its lowest-indexed member.

Top module: `irq_dest_resolver`

## Requirements
- R1: Shorthand code 1 targets only the agent whose index equals the sender index, whatever the destination.
- R2: Shorthand code 2 targets every agent.
- R3: Shorthand code 3 targets every agent except the sender.
- R4: With shorthand code 0 in physical mode (mode bit 0), a destination of all ones targets every agent.
- R5: With shorthand code 0 in physical mode, any other destination targets only the lowest-indexed agent whose ID equals it, or no agent if none does.
- R6: In logical mode (mode bit 1), an agent with model code 0xF matches when the destination ANDed with its logical byte is non-zero.
- R7: In logical mode, an agent with model code 0x0 matches when the upper nibbles of the destination and its logical byte are equal and their lower nibbles share at least one set bit.
- R8: In logical mode, an agent with any other model code never matches.
- R9: When the delivery mode is 3'b001 (lowest priority), the output holds only the lowest set bit of the resolved set, or is zero if the set is empty.
- R10: When the message-signalled select is high, the fields come from the message words and the direct request fields and shorthand are ignored. The destination is address bits [19:12] and the logical-mode bit is address bit 2. The vector is data bits [7:0], the delivery mode is data bits [10:8] and the trigger bit is data bit 15. Address bit 3 (redirection hint) has no effect.
- R11: After reset out_valid is 0 and in_ready is 1. in_ready equals (not out_valid) or out_ready. An accepted request gives out_valid in the next cycle. While out_valid is high and out_ready is low, out_valid and the result stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request accepted this cycle when high together with in_valid |
| in_msi | input | 1 | 1: take fields from msi_addr/msi_data |
| in_dest | input | DEST_W | Direct destination |
| in_logical | input | 1 | Direct mode bit, 1 = logical |
| in_shorthand | input | 2 | Direct shorthand code |
| in_sender | input | IDX_W | Index of the sending agent |
| in_dlv | input | 3 | Direct delivery mode |
| in_vector | input | 8 | Direct vector |
| in_trig | input | 1 | Direct trigger bit |
| msi_addr | input | 32 | Message-signalled address word |
| msi_data | input | 32 | Message-signalled data word |
| agent_id | input | N_AGENTS*DEST_W | Physical ID of each agent, agent i at slice i |
| agent_ldr | input | N_AGENTS*DEST_W | Logical-destination byte of each agent |
| agent_model | input | N_AGENTS*4 | Logical model code of each agent |
| out_valid | output | 1 | Result held |
| out_ready | input | 1 | Consumer takes result |
| out_mask | output | N_AGENTS | Target agent bitmask |
| out_vector | output | 8 | Resolved vector |
| out_trig | output | 1 | Resolved trigger bit |
| out_dlv | output | 3 | Resolved delivery mode |

## Verification
The checker assumes that the sender index on a direct request is always below the agent count. Without that, the self and all-but-self masks would point at a bit that does not exist. It also assumes that the agent ID, logical byte and model code inputs carry meaningful values whenever a request is accepted. The stimulus sets the agent table once, before reset is released, and never changes it. Sender indices are drawn only from the valid range. The consumer's ready signal runs a repeating pattern that stalls one cycle in four, so held results and back-to-back acceptance both occur.

// File: rtl/ids_pkg.sv
`timescale 1ns/1ps
package ids_pkg;
   localparam int VEC_W   = 8;
   localparam int DLV_W   = 3;
   localparam int MODEL_W = 4;
   localparam int MSI_W   = 32;

   // message word field positions
   localparam int MSI_DEST_LSB = 12;
   localparam int MSI_MODE_BIT = 2;
   localparam int MSI_VEC_LSB  = 0;
   localparam int MSI_DLV_LSB  = 8;
   localparam int MSI_TRIG_BIT = 15;

   localparam logic [MODEL_W-1:0] MODEL_FLAT    = 4'hF;
   localparam logic [MODEL_W-1:0] MODEL_CLUSTER = 4'h0;
   localparam logic [DLV_W-1:0]   DLV_LOWEST    = 3'b001;

   typedef enum logic [1:0] {
      SH_FIELD  = 2'd0,
      SH_SELF   = 2'd1,
      SH_ALL    = 2'd2,
      SH_OTHERS = 2'd3
   } shorthand_e;
endpackage

// File: rtl/ids_lowest_pick.sv
`timescale 1ns/1ps
module ids_lowest_pick #(
   parameter int W     = 8,
   parameter bit CHAIN = 1'b0
) (
   input  logic [W-1:0] req_i,
   output logic [W-1:0] pick_o
);
   generate
      if (CHAIN) begin : g_chain
         always_comb begin
            logic seen;
            seen   = 1'b0;
            pick_o = '0;
            for (int i = 0; i < W; i++) begin
               if (req_i[i] && !seen) begin
                  pick_o[i] = 1'b1;
                  seen      = 1'b1;
               end
            end
         end
      end else begin : g_arith
         // two's complement isolates the lowest set bit
         assign pick_o = req_i & (~req_i + {{(W-1){1'b0}}, 1'b1});
      end
   endgenerate
endmodule

// File: rtl/ids_msi_decode.sv
`timescale 1ns/1ps
module ids_msi_decode
   import ids_pkg::*;
#(
   parameter int DEST_W = 8
) (
   input  logic                use_msi,
   input  logic [DEST_W-1:0]   dest_i,
   input  logic                logical_i,
   input  logic [1:0]          sh_i,
   input  logic [DLV_W-1:0]    dlv_i,
   input  logic [VEC_W-1:0]    vec_i,
   input  logic                trig_i,
   input  logic [MSI_W-1:0]    msi_addr,
   input  logic [MSI_W-1:0]    msi_data,
   output logic [DEST_W-1:0]   dest_o,
   output logic                logical_o,
   output shorthand_e          sh_o,
   output logic [DLV_W-1:0]    dlv_o,
   output logic [VEC_W-1:0]    vec_o,
   output logic                trig_o
);
   // hint bit and reserved bits carry no meaning for target resolution
   logic unused_msi_bits;
   assign unused_msi_bits = ^{msi_addr, msi_data};

   always_comb begin
      if (use_msi) begin
         dest_o    = msi_addr[MSI_DEST_LSB +: DEST_W];
         logical_o = msi_addr[MSI_MODE_BIT];
         sh_o      = SH_FIELD;
         dlv_o     = msi_data[MSI_DLV_LSB +: DLV_W];
         vec_o     = msi_data[MSI_VEC_LSB +: VEC_W];
         trig_o    = msi_data[MSI_TRIG_BIT];
      end else begin
         dest_o    = dest_i;
         logical_o = logical_i;
         sh_o      = shorthand_e'(sh_i);
         dlv_o     = dlv_i;
         vec_o     = vec_i;
         trig_o    = trig_i;
      end
   end
endmodule

// File: rtl/ids_match.sv
`timescale 1ns/1ps
module ids_match
   import ids_pkg::*;
#(
   parameter int N_AGENTS = 8,
   parameter int DEST_W   = 8,
   parameter bit CHAIN    = 1'b0
) (
   input  logic [DEST_W-1:0]           dest,
   input  logic                        logical,
   input  logic [N_AGENTS*DEST_W-1:0]  agent_id,
   input  logic [N_AGENTS*DEST_W-1:0]  agent_ldr,
   input  logic [N_AGENTS*MODEL_W-1:0] agent_model,
   output logic [N_AGENTS-1:0]         hit_o
);
   localparam int HALF = DEST_W / 2;

   logic [N_AGENTS-1:0] phys_hit, phys_one, log_hit;

   generate
      for (genvar a = 0; a < N_AGENTS; a++) begin : g_agent
         logic [DEST_W-1:0]  id_a, ldr_a;
         logic [MODEL_W-1:0] model_a;
         logic               flat_ok, clus_ok;
         assign id_a    = agent_id[a*DEST_W +: DEST_W];
         assign ldr_a   = agent_ldr[a*DEST_W +: DEST_W];
         assign model_a = agent_model[a*MODEL_W +: MODEL_W];
         assign phys_hit[a] = (id_a == dest);
         assign flat_ok = (model_a == MODEL_FLAT) && |(dest & ldr_a);
         assign clus_ok = (model_a == MODEL_CLUSTER)
                        && (dest[DEST_W-1:HALF] == ldr_a[DEST_W-1:HALF])
                        && |(dest[HALF-1:0] & ldr_a[HALF-1:0]);
         assign log_hit[a] = flat_ok | clus_ok;
      end
   endgenerate

   ids_lowest_pick #(.W(N_AGENTS), .CHAIN(CHAIN)) u_phys_pick (
      .req_i  (phys_hit),
      .pick_o (phys_one)
   );

   always_comb begin
      if (logical)                  hit_o = log_hit;
      else if (dest == {DEST_W{1'b1}}) hit_o = {N_AGENTS{1'b1}};
      else                          hit_o = phys_one;
   end
endmodule

// File: rtl/ids_target_select.sv
`timescale 1ns/1ps
module ids_target_select
   import ids_pkg::*;
#(
   parameter int N_AGENTS = 8,
   parameter int IDX_W    = 3,
   parameter bit CHAIN    = 1'b0
) (
   input  shorthand_e          sh,
   input  logic [IDX_W-1:0]    sender,
   input  logic [N_AGENTS-1:0] dest_set,
   input  logic                single,
   output logic [N_AGENTS-1:0] mask_o
);
   logic [N_AGENTS-1:0] self_oh, pre, one;

   generate
      for (genvar a = 0; a < N_AGENTS; a++) begin : g_self
         assign self_oh[a] = (sender == IDX_W'(a));
      end
   endgenerate

   always_comb begin
      unique case (sh)
         SH_SELF:   pre = self_oh;
         SH_ALL:    pre = {N_AGENTS{1'b1}};
         SH_OTHERS: pre = ~self_oh;
         default:   pre = dest_set;
      endcase
   end

   ids_lowest_pick #(.W(N_AGENTS), .CHAIN(CHAIN)) u_single (
      .req_i  (pre),
      .pick_o (one)
   );

   assign mask_o = single ? one : pre;
endmodule

// File: rtl/irq_dest_resolver.sv
`timescale 1ns/1ps
module irq_dest_resolver
   import ids_pkg::*;
#(
   parameter int N_AGENTS = 8,
   parameter int DEST_W   = 8,
   parameter bit CHAIN    = 1'b0,
   parameter int IDX_W    = (N_AGENTS > 1) ? $clog2(N_AGENTS) : 1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        in_valid,
   output logic                        in_ready,
   input  logic                        in_msi,
   input  logic [DEST_W-1:0]           in_dest,
   input  logic                        in_logical,
   input  logic [1:0]                  in_shorthand,
   input  logic [IDX_W-1:0]            in_sender,
   input  logic [2:0]                  in_dlv,
   input  logic [7:0]                  in_vector,
   input  logic                        in_trig,
   input  logic [31:0]                 msi_addr,
   input  logic [31:0]                 msi_data,
   input  logic [N_AGENTS*DEST_W-1:0]  agent_id,
   input  logic [N_AGENTS*DEST_W-1:0]  agent_ldr,
   input  logic [N_AGENTS*4-1:0]       agent_model,
   output logic                        out_valid,
   input  logic                        out_ready,
   output logic [N_AGENTS-1:0]         out_mask,
   output logic [7:0]                  out_vector,
   output logic                        out_trig,
   output logic [2:0]                  out_dlv
);
   generate
      if (N_AGENTS < 2) begin : g_bad_agents
         $error("N_AGENTS must be at least 2");
      end
      if ((DEST_W % 2) != 0 || DEST_W < 2) begin : g_bad_dest
         $error("DEST_W must be even and at least 2");
      end
      if (MSI_DEST_LSB + DEST_W > MSI_W) begin : g_bad_msi
         $error("destination field does not fit the message address");
      end
      if ((1 << IDX_W) < N_AGENTS) begin : g_bad_idx
         $error("IDX_W too narrow for N_AGENTS");
      end
   endgenerate

   logic [DEST_W-1:0]   r_dest;
   logic                r_logical, r_trig;
   shorthand_e          r_sh;
   logic [DLV_W-1:0]    r_dlv;
   logic [VEC_W-1:0]    r_vec;
   logic [N_AGENTS-1:0] dest_set, next_mask;
   logic                accept;

   ids_msi_decode #(.DEST_W(DEST_W)) u_dec (
      .use_msi   (in_msi),
      .dest_i    (in_dest),
      .logical_i (in_logical),
      .sh_i      (in_shorthand),
      .dlv_i     (in_dlv),
      .vec_i     (in_vector),
      .trig_i    (in_trig),
      .msi_addr  (msi_addr),
      .msi_data  (msi_data),
      .dest_o    (r_dest),
      .logical_o (r_logical),
      .sh_o      (r_sh),
      .dlv_o     (r_dlv),
      .vec_o     (r_vec),
      .trig_o    (r_trig)
   );

   ids_match #(.N_AGENTS(N_AGENTS), .DEST_W(DEST_W), .CHAIN(CHAIN)) u_match (
      .dest        (r_dest),
      .logical     (r_logical),
      .agent_id    (agent_id),
      .agent_ldr   (agent_ldr),
      .agent_model (agent_model),
      .hit_o       (dest_set)
   );

   ids_target_select #(.N_AGENTS(N_AGENTS), .IDX_W(IDX_W), .CHAIN(CHAIN)) u_sel (
      .sh       (r_sh),
      .sender   (in_sender),
      .dest_set (dest_set),
      .single   (r_dlv == DLV_LOWEST),
      .mask_o   (next_mask)
   );

   assign in_ready = !out_valid || out_ready;
   assign accept   = in_valid && in_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid  <= 1'b0;
         out_mask   <= '0;
         out_vector <= '0;
         out_trig   <= 1'b0;
         out_dlv    <= '0;
      end else if (accept) begin
         out_valid  <= 1'b1;
         out_mask   <= next_mask;
         out_vector <= r_vec;
         out_trig   <= r_trig;
         out_dlv    <= r_dlv;
      end else if (out_ready) begin
         out_valid  <= 1'b0;
      end
   end
endmodule

// File: rtl/irq_dest_resolver_chk.sv
`timescale 1ns/1ps
module irq_dest_resolver_chk
   import ids_pkg::*;
#(
   parameter int N_AGENTS = 8,
   parameter int DEST_W   = 8,
   parameter int IDX_W    = 3
) (
   input logic                clk,
   input logic                rst_n,
   input logic                in_valid,
   input logic                in_ready,
   input logic                in_msi,
   input logic [DEST_W-1:0]   in_dest,
   input logic                in_logical,
   input logic [1:0]          in_shorthand,
   input logic [IDX_W-1:0]    in_sender,
   input logic [2:0]          in_dlv,
   input logic                out_valid,
   input logic                out_ready,
   input logic [N_AGENTS-1:0] out_mask,
   input logic [2:0]          out_dlv
);
   logic take_direct;
   assign take_direct = in_valid && in_ready && !in_msi;

   AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_mask))); // R11
   AST_ACCEPT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> out_valid); // R11
   AST_SINGLE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_dlv == DLV_LOWEST) |-> $onehot0(out_mask)); // R9
   AST_SELF_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (take_direct && in_shorthand == 2'd1)
      |=> (out_mask == (N_AGENTS'(1) << $past(in_sender)))); // R1
   AST_ALL_AGENTS: assert property (@(posedge clk) disable iff (!rst_n)
      (take_direct && in_shorthand == 2'd2 && in_dlv != DLV_LOWEST)
      |=> (&out_mask)); // R2
   AST_SKIP_SENDER: assert property (@(posedge clk) disable iff (!rst_n)
      (take_direct && in_shorthand == 2'd3)
      |=> !out_mask[$past(in_sender)]); // R3
   AST_PHYS_BCAST: assert property (@(posedge clk) disable iff (!rst_n)
      (take_direct && in_shorthand == 2'd0 && !in_logical
       && in_dest == {DEST_W{1'b1}} && in_dlv != DLV_LOWEST)
      |=> (&out_mask)); // R4
endmodule

bind irq_dest_resolver irq_dest_resolver_chk #(
   .N_AGENTS (N_AGENTS),
   .DEST_W   (DEST_W),
   .IDX_W    (IDX_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .in_valid     (in_valid),
   .in_ready     (in_ready),
   .in_msi       (in_msi),
   .in_dest      (in_dest),
   .in_logical   (in_logical),
   .in_shorthand (in_shorthand),
   .in_sender    (in_sender),
   .in_dlv       (in_dlv),
   .out_valid    (out_valid),
   .out_ready    (out_ready),
   .out_mask     (out_mask),
   .out_dlv      (out_dlv)
);

// File: tb/irq_dest_resolver_tb_top.sv
`timescale 1ns/1ps
module irq_dest_resolver_tb_top;
   localparam int N  = 8;
   localparam int DW = 8;
   localparam int IW = 3;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic            rst_n, in_valid, in_ready, in_msi, in_logical, in_trig;
   logic [DW-1:0]   in_dest;
   logic [1:0]      in_shorthand;
   logic [IW-1:0]   in_sender;
   logic [2:0]      in_dlv, out_dlv;
   logic [7:0]      in_vector, out_vector;
   logic [31:0]     msi_addr, msi_data;
   logic [N*DW-1:0] agent_id, agent_ldr;
   logic [N*4-1:0]  agent_model;
   logic            out_valid, out_ready, out_trig;
   logic [N-1:0]    out_mask;

   irq_dest_resolver #(.N_AGENTS(N), .DEST_W(DW)) dut_i (
      .clk, .rst_n, .in_valid, .in_ready, .in_msi, .in_dest, .in_logical,
      .in_shorthand, .in_sender, .in_dlv, .in_vector, .in_trig, .msi_addr,
      .msi_data, .agent_id, .agent_ldr, .agent_model, .out_valid, .out_ready,
      .out_mask, .out_vector, .out_trig, .out_dlv
   );

   typedef struct {
      logic [N-1:0] mask;
      logic [7:0]   vec;
      logic         trig;
      logic [2:0]   dlv;
      string        tag;
   } exp_t;

   exp_t q[$];
   int   n_chk = 0;
   int   n_bad = 0;
   logic [7:0] vec_ctr = 8'h20;

   task automatic check(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
      end
   endtask

   task automatic push_and_send(exp_t e);
      in_valid = 1'b1;
      while (!in_ready) @(negedge clk);
      q.push_back(e);
      @(posedge clk);
   endtask

   task automatic send_dir(string tag, logic [7:0] dest, bit logical, logic [1:0] sh,
                           logic [2:0] sender, logic [2:0] dlv, logic [N-1:0] exp_mask);
      exp_t e;
      @(negedge clk);
      in_msi = 1'b0; in_dest = dest; in_logical = logical; in_shorthand = sh;
      in_sender = sender; in_dlv = dlv; in_vector = vec_ctr; in_trig = vec_ctr[0];
      msi_addr = 32'hFFFF_FFFF; msi_data = 32'hFFFF_FFFF;
      e.mask = exp_mask; e.vec = vec_ctr; e.trig = vec_ctr[0]; e.dlv = dlv; e.tag = tag;
      vec_ctr++;
      push_and_send(e);
   endtask

   task automatic send_msi(string tag, logic [31:0] addr, logic [31:0] data,
                           logic [N-1:0] exp_mask, logic [7:0] ev, bit et, logic [2:0] ed);
      exp_t e;
      @(negedge clk);
      in_msi = 1'b1; msi_addr = addr; msi_data = data;
      // conflicting direct fields that must be ignored (R10)
      in_dest = 8'h00; in_logical = 1'b1; in_shorthand = 2'd2; in_sender = 3'd4;
      in_dlv = 3'd0; in_vector = 8'hEE; in_trig = ~et;
      e.mask = exp_mask; e.vec = ev; e.trig = et; e.dlv = ed; e.tag = tag;
      push_and_send(e);
   endtask

   // consumer ready: stalls one cycle in four, changes well before the falling edge
   initial begin
      int rc;
      rc = 0;
      out_ready = 1'b0;
      forever begin
         @(posedge clk);
         #2;
         rc++;
         out_ready = (rc % 4) != 1;
      end
   end

   // monitor / scoreboard
   initial begin
      bit           prev_stall;
      logic [N-1:0] prev_mask;
      prev_stall = 1'b0;
      prev_mask  = '0;
      forever begin
         @(negedge clk);
         if (rst_n) begin
            if (prev_stall) begin
               check(out_valid && out_mask == prev_mask, "R11", "held result",
                     {23'd0, out_valid, out_mask}, {23'd0, 1'b1, prev_mask});
            end
            if (out_valid && out_ready) begin
               if (q.size() == 0) begin
                  check(1'b0, "R11", "unexpected result", {24'd0, out_mask}, 32'd0);
               end else begin
                  exp_t e;
                  e = q.pop_front();
                  check(out_mask == e.mask, e.tag, "mask", {24'd0, out_mask}, {24'd0, e.mask});
                  check({out_vector, out_trig, out_dlv} == {e.vec, e.trig, e.dlv}, e.tag,
                        "vector/trig/dlv", {20'd0, out_vector, out_trig, out_dlv},
                        {20'd0, e.vec, e.trig, e.dlv});
               end
            end
            prev_stall = out_valid && !out_ready;
            prev_mask  = out_mask;
         end
      end
   end

   initial begin
      repeat (50000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL R11 watchdog expired act=%0d exp=%0d", q.size(), 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      rst_n = 1'b0; in_valid = 1'b0; in_msi = 1'b0; in_dest = '0; in_logical = 1'b0;
      in_shorthand = '0; in_sender = '0; in_dlv = '0; in_vector = '0; in_trig = 1'b0;
      msi_addr = '0; msi_data = '0;
      // agent table: IDs 0x10+i (agent 6 duplicates 0x12), models F,F,F,F,0,0,0,5
      for (int i = 0; i < N; i++) agent_id[i*DW +: DW] = 8'h10 + 8'(i);
      agent_id[6*DW +: DW] = 8'h12;
      agent_ldr   = {8'hFF, 8'h31, 8'h22, 8'h21, 8'h08, 8'h04, 8'h02, 8'h01};
      agent_model = {4'h5, 4'h0, 4'h0, 4'h0, 4'hF, 4'hF, 4'hF, 4'hF};
      repeat (4) @(negedge clk);
      check(out_valid == 1'b0, "R11", "reset out_valid", {31'd0, out_valid}, 32'd0);
      check(in_ready == 1'b1, "R11", "reset in_ready", {31'd0, in_ready}, 32'd1);
      rst_n = 1'b1;

      send_dir("R5", 8'h13, 0, 2'd0, 3'd0, 3'd0, 8'h08);
      send_dir("R5", 8'h12, 0, 2'd0, 3'd0, 3'd0, 8'h04); // duplicate ID: lowest index
      send_dir("R5", 8'h55, 0, 2'd0, 3'd0, 3'd0, 8'h00);
      send_dir("R4", 8'hFF, 0, 2'd0, 3'd0, 3'd0, 8'hFF);
      send_dir("R6", 8'h05, 1, 2'd0, 3'd0, 3'd0, 8'h05);
      send_dir("R7", 8'h23, 1, 2'd0, 3'd0, 3'd0, 8'h33);
      send_dir("R7", 8'h24, 1, 2'd0, 3'd0, 3'd0, 8'h04);
      send_dir("R8", 8'hF0, 1, 2'd0, 3'd0, 3'd0, 8'h00);
      send_dir("R1", 8'h13, 0, 2'd1, 3'd5, 3'd0, 8'h20);
      send_dir("R1", 8'hFF, 0, 2'd1, 3'd0, 3'd0, 8'h01);
      send_dir("R2", 8'h55, 1, 2'd2, 3'd3, 3'd0, 8'hFF);
      send_dir("R3", 8'h13, 0, 2'd3, 3'd0, 3'd0, 8'hFE);
      send_dir("R3", 8'h13, 0, 2'd3, 3'd7, 3'd2, 8'h7F);
      send_dir("R9", 8'h23, 1, 2'd0, 3'd0, 3'd1, 8'h01);
      send_dir("R9", 8'h13, 0, 2'd3, 3'd0, 3'd1, 8'h02);
      send_dir("R9", 8'hFF, 0, 2'd0, 3'd0, 3'd1, 8'h01);
      send_dir("R9", 8'h55, 0, 2'd0, 3'd0, 3'd1, 8'h00);
      send_msi("R10", 32'h0001_3008, 32'h0000_8041, 8'h08, 8'h41, 1'b1, 3'd0);
      send_msi("R10", 32'h0002_3004, 32'h0000_0130, 8'h01, 8'h30, 1'b0, 3'd1);
      send_msi("R10", 32'h000F_F000, 32'h0000_0055, 8'hFF, 8'h55, 1'b0, 3'd0);

      @(negedge clk);
      in_valid = 1'b0;
      while (q.size() != 0) @(negedge clk);
      repeat (2) @(negedge clk);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule